// File: doc/BRIEF.md
# Byte-Wide Chained Configuration Loader

This block takes a configuration stream from a shared eight-bit bus, one byte on every rising edge of a configuration clock that is driven from outside the device. Every loader on the bus watches the same bytes. Each one hunts for a sync byte, reads the big-endian length count that follows it, and then counts down the body bytes of the stream. Only a loader whose chain-enable input is high, whose ready delay has run out and whose local memory still has room keeps body bytes. It writes them through a simple write port into its configuration memory.

The body is cut into frames. Each frame is a fixed number of data bytes followed by one stop byte. A wrong stop byte raises a sticky error and stops all further writes. No CRC is computed. After `init_hi` is seen high, the status output stays high for two slow-oscillator ticks and then drops low. It goes high again once the stop byte of the last frame has been accepted. On a shared bus that rising edge drives the next loader's chain-enable input, so the following bytes go to that device. The first device in a chain has its chain-enable tied high.

Top module: `cfg_chain_loader`

## Requirements
- R1: During and after reset, `status_out` is 1, `mem_we` is 0 and `cfg_err` is 0.
- R2: The READY_TICKS-th (default 2) `osc_tick` pulse counts once `init_hi` has been sampled high on an earlier edge. After the edge that samples that pulse, `status_out` is 0. Before it, `status_out` stays 1.
- R3: A byte that arrives while `status_out` is 1 is never written.
- R4: While hunting, every byte other than SYNC_BYTE (default 8'hB7) is skipped. After a sync byte come LEN_BYTES (default 3) length bytes, most significant first. The header is decoded whatever the level of `chain_en`.
- R5: The length count is the number of body bytes that follow the header. Once that many bytes have passed, or at once if the count is zero, the loader hunts again, and bytes that are not a sync byte produce no write.
- R6: An accepted body byte is written in the cycle after the edge that captured it. `mem_we` is 1 for that cycle, `mem_wdata` equals the byte, and `mem_addr` runs 0, 1, 2, ... over the data bytes. Each frame is FRAME_BYTES data bytes followed by one stop byte, and the stop byte is not written.
- R7: A body byte seen while `chain_en` is 0 is counted against the length but is not written, and the frame position does not move.
- R8: The stop byte must be 8'hFE. Any other value sets `cfg_err`, which stays 1 until reset, and no write happens after that.
- R9: When the stop byte of frame NUM_FRAMES is accepted, `status_out` goes to 1 on that edge and stays 1, and no byte is written afterwards.
- R10: Frame and address progress is kept when a stream ends before memory is full. A new sync and header resume writing at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from outside; data is captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_hi | input | 1 | Init released; the ready delay starts once this is seen high |
| osc_tick | input | 1 | Single-cycle slow-oscillator tick, synchronous to `clk` |
| chain_en | input | 1 | Chain enable; high lets this device keep frame data |
| din | input | 8 | Shared configuration byte bus |
| mem_we | output | 1 | Configuration memory write strobe |
| mem_addr | output | AW | Configuration memory write address |
| mem_wdata | output | 8 | Configuration memory write data |
| status_out | output | 1 | Low while loading; high before ready and once memory is full |
| cfg_err | output | 1 | Sticky stop-byte mismatch flag |

## Verification
The load path is driven by four stream patterns:
- Filler before a sync byte separates hunting from header parsing.
- A header and body bytes sent with chain-enable low, followed by enabled data, show that the header is decoded while disabled and that disabled bytes still use up the length.
- A short stream that ends mid-load, then stray bytes, then a second header, shows that the loader stops at the length boundary and resumes at the right address.
- A corrupted stop byte separates the error path from the normal frame close.

A full stream sent before the ready delay has run out tells the ready gate apart from the chain-enable gate. Ticks sent one at a time show on which edge the status output falls.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   typedef enum logic [1:0] {
      PS_HUNT,
      PS_LEN,
      PS_BODY
   } parse_st_t;

   localparam logic [7:0] STOP_CODE = 8'hFE;
endpackage

// File: rtl/cfgl_ready_timer.sv
// Counts slow-oscillator ticks after init is seen; ready once TICKS are counted.
module cfgl_ready_timer #(
   parameter int TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_hi,
   input  logic osc_tick,
   output logic ready
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= armed | init_hi;
   end

   generate
      if (TICKS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)                 ready <= 1'b0;
            else if (armed && osc_tick) ready <= 1'b1;
         end
      end else begin : g_count
         localparam int CW = $clog2(TICKS + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (armed && osc_tick && (cnt != CW'(TICKS)))
               cnt <= cnt + 1'b1;
         end
         assign ready = (cnt == CW'(TICKS));
      end
   endgenerate
endmodule

// File: rtl/cfgl_hdr_parser.sv
// Hunts for sync, shifts in the length count, then flags body bytes until it runs out.
module cfgl_hdr_parser
   import cfgl_pkg::*;
#(
   parameter logic [7:0] SYNC_BYTE = 8'hB7,
   parameter int         LEN_BYTES = 3,
   localparam int        RW        = 8 * LEN_BYTES,
   localparam int        LCW       = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] din,
   output logic       body
);
   parse_st_t        st;
   logic [RW-1:0]    rem;
   logic [RW-1:0]    rem_shift;
   logic [LCW-1:0]   lcnt;

   generate
      if (LEN_BYTES == 1) begin : g_one
         assign rem_shift = din;
      end else begin : g_multi
         assign rem_shift = {rem[RW-9:0], din};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= PS_HUNT;
         rem  <= '0;
         lcnt <= '0;
      end else begin
         case (st)
            PS_HUNT: begin
               if (din == SYNC_BYTE) begin
                  st   <= PS_LEN;
                  lcnt <= '0;
               end
            end
            PS_LEN: begin
               rem <= rem_shift;
               if (lcnt == LCW'(LEN_BYTES - 1))
                  st <= (rem_shift == '0) ? PS_HUNT : PS_BODY;
               else
                  lcnt <= lcnt + 1'b1;
            end
            PS_BODY: begin
               rem <= rem - 1'b1;
               if (rem == RW'(1)) st <= PS_HUNT;
            end
            default: st <= PS_HUNT;
         endcase
      end
   end

   assign body = (st == PS_BODY);
endmodule

// File: rtl/cfgl_frame_writer.sv
// Splits accepted body bytes into data and stop bytes, drives the write port.
module cfgl_frame_writer
   import cfgl_pkg::*;
#(
   parameter int  FRAME_BYTES = 4,
   parameter int  NUM_FRAMES  = 3,
   parameter int  AW          = 4,
   localparam int PW          = $clog2(FRAME_BYTES + 1),
   localparam int FW          = $clog2(NUM_FRAMES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [7:0]    din,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   output logic          full,
   output logic          err
);
   logic [PW-1:0] pos;
   logic [FW-1:0] frm;
   logic [AW-1:0] wa;
   logic          accept;

   assign accept = take & ~full & ~err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         pos       <= '0;
         frm       <= '0;
         wa        <= '0;
         full      <= 1'b0;
         err       <= 1'b0;
      end else begin
         mem_we <= 1'b0;
         if (accept) begin
            if (pos != PW'(FRAME_BYTES)) begin
               mem_we    <= 1'b1;
               mem_addr  <= wa;
               mem_wdata <= din;
               wa        <= wa + 1'b1;
               pos       <= pos + 1'b1;
            end else if (din == STOP_CODE) begin
               pos <= '0;
               if (frm == FW'(NUM_FRAMES - 1)) full <= 1'b1;
               else                            frm  <= frm + 1'b1;
            end else begin
               err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
   parameter int         FRAME_BYTES = 4,
   parameter int         NUM_FRAMES  = 3,
   parameter int         LEN_BYTES   = 3,
   parameter int         READY_TICKS = 2,
   parameter logic [7:0] SYNC_BYTE   = 8'hB7,
   localparam int        DEPTH       = FRAME_BYTES * NUM_FRAMES,
   localparam int        AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_hi,
   input  logic          osc_tick,
   input  logic          chain_en,
   input  logic [7:0]    din,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   output logic          status_out,
   output logic          cfg_err
);
   generate
      if (FRAME_BYTES < 1) begin : g_bad_fb
         $error("FRAME_BYTES must be at least 1");
      end
      if (NUM_FRAMES < 1) begin : g_bad_nf
         $error("NUM_FRAMES must be at least 1");
      end
      if (LEN_BYTES < 1 || LEN_BYTES > 4) begin : g_bad_lb
         $error("LEN_BYTES must be 1 to 4");
      end
      if (READY_TICKS < 1) begin : g_bad_rt
         $error("READY_TICKS must be at least 1");
      end
   endgenerate

   logic ready;
   logic body;
   logic full;

   cfgl_ready_timer #(.TICKS(READY_TICKS)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_hi  (init_hi),
      .osc_tick (osc_tick),
      .ready    (ready)
   );

   cfgl_hdr_parser #(.SYNC_BYTE(SYNC_BYTE), .LEN_BYTES(LEN_BYTES)) parser_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .body  (body)
   );

   cfgl_frame_writer #(
      .FRAME_BYTES (FRAME_BYTES),
      .NUM_FRAMES  (NUM_FRAMES),
      .AW          (AW)
   ) writer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (body & chain_en & ready),
      .din       (din),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .full      (full),
      .err       (cfg_err)
   );

   assign status_out = ~ready | full;
endmodule

// File: rtl/cfg_chain_loader_chk.sv
module cfg_chain_loader_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          osc_tick,
   input logic          chain_en,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          status_out,
   input logic          cfg_err
);
   logic [AW:0] wr_cnt;
   logic        low_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt   <= '0;
         low_seen <= 1'b0;
      end else begin
         if (mem_we)      wr_cnt   <= wr_cnt + 1'b1;
         if (!status_out) low_seen <= 1'b1;
      end
   end

   // R2: status falls only on the edge after a tick was sampled
   p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_out) |-> $past(osc_tick));

   // R3 and R9: no write follows a cycle with status high
   p_no_write_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !$past(status_out));

   // R6: write addresses run in order from zero
   p_addr_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == wr_cnt[AW-1:0]));

   // R7: a write needs chain enable high on the capturing edge
   p_no_write_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(chain_en));

   // R8: error is sticky
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   // R8: no write once the error is up
   p_no_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_err) |-> !mem_we);

   // R9: once loading began, a high status stays high
   p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (low_seen && status_out) |=> status_out);
endmodule

bind cfg_chain_loader cfg_chain_loader_chk #(.AW(AW)) chk_i (.*);

// File: tb/cfg_chain_loader_tb_top.sv
module cfg_chain_loader_tb_top;
   localparam int FB  = 4;
   localparam int NF  = 3;
   localparam int AW  = 4;
   localparam logic [7:0] SYNC = 8'hB7;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          init_hi;
   logic          osc_tick;
   logic          chain_en;
   logic [7:0]    din;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          status_out;
   logic          cfg_err;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   cfg_chain_loader dut_i (
      .clk(clk), .rst_n(rst_n), .init_hi(init_hi), .osc_tick(osc_tick),
      .chain_en(chain_en), .din(din), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .status_out(status_out), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; init_hi = 1'b0; osc_tick = 1'b0; chain_en = 1'b1; din = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive one byte, return just after the capturing edge
   task automatic push(input logic [7:0] b, input logic en);
      @(negedge clk);
      din = b; chain_en = en; osc_tick = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic push_chk(input logic [7:0] b, input logic en, input bit exp_we,
                           input int exp_addr, input string req);
      push(b, en);
      chk(mem_we == exp_we, req, mem_we, exp_we);
      if (exp_we) begin
         chk(mem_addr == AW'(exp_addr), req, mem_addr, exp_addr);
         chk(mem_wdata == b, req, mem_wdata, b);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      osc_tick = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      osc_tick = 1'b0;
   endtask

   task automatic header(input int len, input logic en);
      push(SYNC, en);
      push(8'((len >> 16) & 255), en);
      push(8'((len >> 8) & 255), en);
      push(8'(len & 255), en);
   endtask

   function automatic logic [7:0] dbyte(input int a);
      return 8'(8'h30 + a * 7);
   endfunction

   task automatic make_ready();
      @(negedge clk);
      init_hi = 1'b1;
      @(posedge clk);
      tick();
      tick();
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk(status_out == 1'b1, "R1 status", status_out, 1);
      chk(mem_we == 1'b0, "R1 we", mem_we, 0);
      chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);
   endtask

   task automatic t_unready();
      // whole stream before ready: nothing may be written (R3)
      header(FB + 1, 1'b1);
      for (int i = 0; i < FB; i++) push_chk(dbyte(i), 1'b1, 1'b0, 0, "R3 unready");
      push_chk(8'hFE, 1'b1, 1'b0, 0, "R3 unready stop");
   endtask

   task automatic t_ready();
      @(negedge clk);
      init_hi = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(status_out == 1'b1, "R2 no tick yet", status_out, 1);
      tick();
      chk(status_out == 1'b1, "R2 one tick", status_out, 1);
      repeat (2) @(posedge clk);
      tick();
      chk(status_out == 1'b0, "R2 two ticks", status_out, 0);
   endtask

   task automatic t_chain_load();
      push_chk(8'hFF, 1'b1, 1'b0, 0, "R4 filler");
      push_chk(8'h00, 1'b1, 1'b0, 0, "R4 filler");
      // header decoded while disabled (R4), two disabled body bytes (R7)
      header(2 + FB + 1, 1'b0);
      push_chk(8'hAA, 1'b0, 1'b0, 0, "R7 disabled");
      push_chk(8'hBB, 1'b0, 1'b0, 0, "R7 disabled");
      for (int i = 0; i < FB; i++) push_chk(dbyte(i), 1'b1, 1'b1, i, "R6 frame0");
      push_chk(8'hFE, 1'b1, 1'b0, 0, "R6 stop");
      chk(status_out == 1'b0, "R9 not full yet", status_out, 0);
      // stream ended: hunting, stray bytes not written (R5)
      push_chk(8'h11, 1'b1, 1'b0, 0, "R5 after length");
      push_chk(8'h22, 1'b1, 1'b0, 0, "R5 after length");
      push_chk(8'h33, 1'b1, 1'b0, 0, "R5 after length");
      // resume at next address (R10)
      header((NF - 1) * (FB + 1) + 2, 1'b1);
      for (int f = 1; f < NF; f++) begin
         for (int i = 0; i < FB; i++)
            push_chk(dbyte(f * FB + i), 1'b1, 1'b1, f * FB + i, "R10 resume");
         push_chk(8'hFE, 1'b1, 1'b0, 0, "R6 stop");
      end
      chk(status_out == 1'b1, "R9 full", status_out, 1);
      push_chk(8'h44, 1'b1, 1'b0, 0, "R9 after full");
      push_chk(8'h55, 1'b1, 1'b0, 0, "R9 after full");
      chk(status_out == 1'b1, "R9 stays high", status_out, 1);
      chk(cfg_err == 1'b0, "R8 no error", cfg_err, 0);
      header(FB + 1, 1'b1);
      push_chk(8'h66, 1'b1, 1'b0, 0, "R9 new stream");
   endtask

   task automatic t_zero_len();
      do_reset();
      make_ready();
      header(0, 1'b1);
      push_chk(8'h5A, 1'b1, 1'b0, 0, "R5 zero length");
      header(FB + 1, 1'b1);
      push_chk(dbyte(0), 1'b1, 1'b1, 0, "R5 after zero length");
   endtask

   task automatic t_error();
      do_reset();
      make_ready();
      header(20, 1'b1);
      for (int i = 0; i < FB; i++) push_chk(dbyte(i), 1'b1, 1'b1, i, "R6 before error");
      push_chk(8'h55, 1'b1, 1'b0, 0, "R8 bad stop");
      chk(cfg_err == 1'b1, "R8 error set", cfg_err, 1);
      for (int i = 0; i < FB; i++) push_chk(dbyte(i), 1'b1, 1'b0, 0, "R8 no write");
      push_chk(8'hFE, 1'b1, 1'b0, 0, "R8 no write");
      chk(cfg_err == 1'b1, "R8 sticky", cfg_err, 1);
      chk(status_out == 1'b0, "R8 status low", status_out, 0);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_unready();
      t_ready();
      t_chain_load();
      t_zero_len();
      t_error();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule